// File: doc/BRIEF.md
# Interrupt Flag Controller for an 8-bit Core

This block gathers the interrupt events of a small 8-bit processor core and turns them into one interrupt request and one wake-up request. Three sources feed it: a one-cycle overflow pulse from a timer, a single external pin whose active edge is picked by a polarity bit, and a change detector on a chosen subset of general-purpose input pins. Each source has a sticky flag and an enable bit. All flags and enables, plus a global enable, live in one 8-bit control register. A second 8-bit option register holds the edge polarity bit. The core reads and writes both registers over a simple one-address-bit bus.

The global enable is kept by a small state machine with three states. `ST_MASKED` means the global enable was cleared by reset or by software. `ST_OPEN` means the global enable is set. `ST_SERVICE` means the global enable was cleared because the core took the interrupt vector. The transitions are:
- `ST_MASKED` to `ST_OPEN` on a return strobe or a software write of 1.
- `ST_OPEN` to `ST_SERVICE` when the vector is taken while the request is high.
- `ST_OPEN` to `ST_MASKED` on a software write of 0.
- `ST_SERVICE` to `ST_OPEN` on a return strobe or a software write of 1.

The wake request ignores the global enable. A sleeping core can therefore be woken by any enabled, flagged source, and the global enable then decides whether the core branches to the vector. The controller saves no context: the core keeps only its return address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and the option register (address 1) reads 0xFF. Both `irq_req` and `wake_req` are 0.
- R2: A high `tmr_ovf` sampled at a clock edge sets the timer flag, control bit 2, at that edge.
- R3: The external pin passes through two synchronizer flops and is compared with its previous synchronized value. When option bit 6 is 1, a rising edge sets the external flag (control bit 1). When option bit 6 is 0, a falling edge sets it. The edge of the other direction has no effect. The flag reads set three edges after the pin changes.
- R4: A level change in either direction on `gp_pins` bit 0, 1 or 3 sets the change flag (control bit 0), with the same three-edge latency. Changes on bits 2, 4 and 5 have no effect.
- R5: Flags are never cleared by hardware. A bus write to address 0 loads each flag from the written bit, so writing 0 clears a flag and writing 1 sets it.
- R6: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R7: `irq_req` is 1 exactly when control bit 7 (global enable) is 1 and at least one source has both its flag and its enable set. The enables are bit 5 (timer), bit 4 (external) and bit 3 (change).
- R8: `wake_req` is 1 exactly when at least one source has both its flag and its enable set, whatever the global enable holds.
- R9: A `vec_take` pulse while `irq_req` is 1 clears the global enable at that edge and leaves the flags untouched. A `vec_take` while `irq_req` is 0 is ignored.
- R10: A `ret_strobe` pulse sets the global enable at that edge. A vector take in the same cycle takes priority.
- R11: `rd_data` shows the register selected by `addr` without a clock delay. Control bit 6 reads 0 and ignores writes.
- R12: All 8 bits of the option register can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 1 | Register select: 0 control, 1 option |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Bus read data of the selected register |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| gp_pins | input | 6 | General-purpose inputs watched for change (asynchronous) |
| vec_take | input | 1 | Core is branching to the interrupt vector |
| ret_strobe | input | 1 | Core executed a return from interrupt |
| irq_req | output | 1 | Interrupt request, gated by the global enable |
| wake_req | output | 1 | Wake-up request, not gated by the global enable |

## Verification
The checker watches four things on every cycle:
- a timer pulse always leaves its flag set, even against a clearing write;
- a set flag stays set unless software writes it to 0;
- the request implies both the global enable and the wake request, and the reverse holds when the global enable is set;
- taking the vector or returning moves the global enable the next cycle.

The three-edge synchronizer latency, the choice of edge polarity, the pin mask of the change detector, and the full mapping from enable, flag and global-enable patterns to the two outputs can only be shown by the bench's sweeps. The bench drives pin transitions and all register patterns, then compares against values it works out itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Number of interrupt sources and their flag positions in the control register
    localparam int NSRC      = 3;
    localparam int BIT_CHG   = 0;
    localparam int BIT_EXT   = 1;
    localparam int BIT_TMR   = 2;
    localparam int EN_OFFSET = 3;   // enable of source k sits at bit k+3
    localparam int BIT_GIE   = 7;

    typedef enum logic [1:0] {
        ST_MASKED  = 2'd0,
        ST_OPEN    = 2'd1,
        ST_SERVICE = 2'd2
    } gie_state_t;

endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wr_flag_i,
    input  logic [N-1:0] wr_en_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] en_o,
    output logic         pend_o
);

    logic [N-1:0] flag_q;
    logic [N-1:0] en_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_src
            // hardware set has priority over a software load
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    flag_q[g] <= 1'b0;
                else if (set_i[g]) flag_q[g] <= 1'b1;
                else if (wr_i) flag_q[g] <= wr_flag_i[g];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    en_q[g] <= 1'b0;
                else if (wr_i) en_q[g] <= wr_en_i[g];
            end
        end
    endgenerate

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign pend_o = |(flag_q & en_q);

endmodule

// File: rtl/irqc_gie_fsm.sv
module irqc_gie_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic ret_i,
    input  logic sw_wr_i,
    input  logic sw_gie_i,
    output logic gie_o
);

    gie_state_t state_q;
    gie_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED: begin
                if (ret_i || (sw_wr_i && sw_gie_i)) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (take_i)                        state_d = ST_SERVICE;
                else if (ret_i)                    state_d = ST_OPEN;
                else if (sw_wr_i && !sw_gie_i)     state_d = ST_MASKED;
            end
            ST_SERVICE: begin
                if (ret_i || (sw_wr_i && sw_gie_i)) state_d = ST_OPEN;
            end
            default: state_d = ST_MASKED;
        endcase
    end

    always_comb begin
        gie_o = 1'b0;
        unique case (state_q)
            ST_OPEN:    gie_o = 1'b1;
            ST_MASKED,
            ST_SERVICE: gie_o = 1'b0;
            default:    gie_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int                NUM_GP      = 6,
    parameter logic [NUM_GP-1:0] CHG_MASK    = 6'b001011,
    parameter logic [7:0]        OPT_RESET   = 8'hFF,
    parameter int                POL_BIT     = 6,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [NUM_GP-1:0] gp_pins,
    input  logic              vec_take,
    input  logic              ret_strobe,
    output logic              irq_req,
    output logic              wake_req
);

    localparam int EN_HI = EN_OFFSET + NSRC - 1;

    logic [7:0]        opt_q;
    logic [7:0]        ctrl_q;
    logic              ctrl_wr;
    logic              ext_rise;
    logic              ext_fall;
    logic              ext_hit;
    logic [NUM_GP-1:0] gp_rise;
    logic [NUM_GP-1:0] gp_fall;
    logic              chg_hit;
    logic [NSRC-1:0]   hw_set;
    logic [NSRC-1:0]   flag_v;
    logic [NSRC-1:0]   en_v;
    logic              pend;
    logic              gie;
    logic              take;

    assign ctrl_wr = wr_en && (addr == 1'b0);

    // option register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       opt_q <= OPT_RESET;
        else if (wr_en && addr == 1'b1)   opt_q <= wr_data;
    end

    // external pin edge detection
    irqc_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    assign ext_hit = opt_q[POL_BIT] ? ext_rise : ext_fall;

    // pin-change detection
    generate
        for (genvar p = 0; p < NUM_GP; p++) begin : g_gp
            irqc_sync_edge #(.STAGES(SYNC_STAGES)) u_gp_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (gp_pins[p]),
                .rise_o (gp_rise[p]),
                .fall_o (gp_fall[p])
            );
        end
    endgenerate

    assign chg_hit = |((gp_rise | gp_fall) & CHG_MASK);

    always_comb begin
        hw_set          = '0;
        hw_set[BIT_CHG] = chg_hit;
        hw_set[BIT_EXT] = ext_hit;
        hw_set[BIT_TMR] = tmr_ovf;
    end

    irqc_flags #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (hw_set),
        .wr_i      (ctrl_wr),
        .wr_flag_i (wr_data[NSRC-1:0]),
        .wr_en_i   (wr_data[EN_HI:EN_OFFSET]),
        .flag_o    (flag_v),
        .en_o      (en_v),
        .pend_o    (pend)
    );

    assign take = vec_take && irq_req;

    irqc_gie_fsm u_gie (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .ret_i    (ret_strobe),
        .sw_wr_i  (ctrl_wr),
        .sw_gie_i (wr_data[BIT_GIE]),
        .gie_o    (gie)
    );

    assign ctrl_q   = {gie, 1'b0, en_v, flag_v};
    assign irq_req  = gie && pend;
    assign wake_req = pend;
    assign rd_data  = addr ? opt_q : ctrl_q;

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wr_data,
    input logic       tmr_ovf,
    input logic       vec_take,
    input logic       ret_strobe,
    input logic       irq_req,
    input logic       wake_req,
    input logic [7:0] ctrl_q
);

    // R2 / R6: timer pulse always leaves its flag set, even against a clearing write
    assert_tmr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctrl_q[2]);

    // R5: a set flag survives unless software writes it to 0
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1] && !(wr_en && !addr && !wr_data[1])) |=> ctrl_q[1]);

    // R7: request only with global enable
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl_q[7]);

    // R7: with global enable open, any wake cause is a request
    assert_irq_when_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && wake_req) |-> irq_req);

    // R8: request implies wake
    assert_wake_superset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_req);

    // R9: vector taken clears global enable
    assert_vector_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && vec_take) |=> !ctrl_q[7]);

    // R10: return sets global enable unless a vector take wins
    assert_return_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !(irq_req && vec_take)) |=> ctrl_q[7]);

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .tmr_ovf    (tmr_ovf),
    .vec_take   (vec_take),
    .ret_strobe (ret_strobe),
    .irq_req    (irq_req),
    .wake_req   (wake_req),
    .ctrl_q     (ctrl_q)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b0;
    logic [5:0] gp_pins = 6'b0;
    logic       vec_take = 1'b0;
    logic       ret_strobe = 1'b0;
    logic       irq_req;
    logic       wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .tmr_ovf    (tmr_ovf),
        .ext_pin    (ext_pin),
        .gp_pins    (gp_pins),
        .vec_take   (vec_take),
        .ret_strobe (ret_strobe),
        .irq_req    (irq_req),
        .wake_req   (wake_req)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        logic exp_ext;
        logic exp_chg;
        logic any;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(1'b0, v); chk(v, 8'h00, "R1 ctrl reset");
        rd(1'b1, v); chk(v, 8'hFF, "R1 option reset");
        chk({7'd0, irq_req}, 8'd0, "R1 irq_req reset");
        chk({7'd0, wake_req}, 8'd0, "R1 wake_req reset");

        // R12 option register readback
        for (int i = 0; i < 16; i++) begin
            wr(1'b1, 8'(i * 17 + 3));
            rd(1'b1, v); chk(v, 8'(i * 17 + 3), "R12 option readback");
        end

        // R2 timer flag, R5 stickiness and clear
        tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
        rd(1'b0, v); chk(v, 8'h04, "R2 timer flag set");
        tick(5);
        rd(1'b0, v); chk(v, 8'h04, "R5 timer flag held");
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk(v, 8'h00, "R5 flag cleared by write 0");

        // R6 set wins over clear in same cycle
        tmr_ovf = 1'b1; wr(1'b0, 8'h00); tmr_ovf = 1'b0;
        rd(1'b0, v); chk(v & 8'h04, 8'h04, "R6 set beats clear");
        wr(1'b0, 8'h00);

        // R3 external edge by polarity and direction
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 2; d++) begin
                wr(1'b1, p[0] ? 8'hFF : 8'hBF);
                ext_pin = ~d[0];
                tick(4);
                wr(1'b0, 8'h00);
                ext_pin = d[0];
                tick(3);
                exp_ext = (p == d);
                rd(1'b0, v); chk({7'd0, v[1]}, {7'd0, exp_ext}, "R3 external edge flag");
            end
        end
        ext_pin = 1'b0; tick(4); wr(1'b0, 8'h00);

        // R4 pin-change mask sweep, both directions
        for (int p = 0; p < 6; p++) begin
            exp_chg = (p == 0) || (p == 1) || (p == 3);
            for (int lv = 1; lv >= 0; lv--) begin
                wr(1'b0, 8'h00);
                gp_pins[p] = lv[0];
                tick(3);
                rd(1'b0, v); chk({7'd0, v[0]}, {7'd0, exp_chg}, "R4 pin change flag");
            end
        end
        wr(1'b0, 8'h00);

        // R7 R8 R11 sweep of global enable, enables and flags
        for (int g = 0; g < 2; g++) begin
            for (int en = 0; en < 8; en++) begin
                for (int fl = 0; fl < 8; fl++) begin
                    wr(1'b0, {g[0], 1'b1, en[2:0], fl[2:0]});
                    any = |(en[2:0] & fl[2:0]);
                    rd(1'b0, v);
                    chk(v, {g[0], 1'b0, en[2:0], fl[2:0]}, "R11 ctrl readback");
                    chk({7'd0, irq_req}, {7'd0, g[0] & any}, "R7 irq_req");
                    chk({7'd0, wake_req}, {7'd0, any}, "R8 wake_req");
                end
            end
        end

        // R9 / R10 vectoring and return
        wr(1'b0, 8'b1010_0100);
        chk({7'd0, irq_req}, 8'd1, "R7 irq before vector");
        vec_take = 1'b1; tick(1); vec_take = 1'b0;
        rd(1'b0, v);
        chk(v, 8'b0010_0100, "R9 vector clears global enable only");
        chk({7'd0, irq_req}, 8'd0, "R9 irq_req low after vector");
        chk({7'd0, wake_req}, 8'd1, "R8 wake kept after vector");
        ret_strobe = 1'b1; tick(1); ret_strobe = 1'b0;
        rd(1'b0, v); chk(v, 8'b1010_0100, "R10 return sets global enable");
        chk({7'd0, irq_req}, 8'd1, "R10 irq_req back");
        wr(1'b0, 8'b1010_0000);
        vec_take = 1'b1; tick(1); vec_take = 1'b0;
        rd(1'b0, v); chk(v, 8'b1010_0000, "R9 vector ignored without request");
        wr(1'b0, 8'h00);
        ret_strobe = 1'b1; tick(1); ret_strobe = 1'b0;
        rd(1'b0, v); chk(v, 8'h80, "R10 return from masked state");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule